// File: doc/BRIEF.md
# 64-bit System Timer with Match Interrupt

The block keeps a free-running 64-bit timestamp that advances by one on every cycle in which the `tick` input is high. A single 64-bit match value can be armed against it. When matching is enabled and the timestamp has reached or passed the match value, a sticky event flag is raised and drives an interrupt line. Software clears the flag by writing a one to it.

All access goes through a 32-bit register port. Each access is a single cycle: address and strobe in one cycle, write data taken at the clock edge, read data returned combinationally in the same cycle. The 64-bit quantities are split into two words. Reads and writes of the two halves are made coherent in hardware, so a carry between two accesses does not tear the value.

To arm a match, software disables matching, reads the timestamp, writes the timestamp plus a delta of at least 100 ticks as the match value, and re-enables matching. The enable bit changes only when a guard bit is also set in the same control write.

Top module: `systmr_top`

## Requirements
- R1: The timestamp increments by one (modulo 2^64) at each clock edge where `tick` is 1 and holds otherwise. Reading byte address 0x00 returns its low 32 bits at the current value.
- R2: A read of 0x00 stores the timestamp's current upper 32 bits in a snapshot register. A read of 0x04 returns that snapshot and not the live upper word, so that a 0x00 read followed by a 0x04 read always yields the 64-bit value seen at the 0x00 read.
- R3: A write to 0x0C loads a pending upper-half register and leaves the active match value unchanged. Reads of 0x08 and 0x0C return the low and high halves of the active match value.
- R4: A write to 0x08 sets the active 64-bit match value to {pending upper half, written data} in one step.
- R5: A write to 0x10 updates the enable bit (bit 0) with wdata[0] only when wdata[1] is 1, and otherwise leaves it unchanged. A read of 0x10 returns the enable in bit 0 and zero in all other bits, bit 1 included.
- R6: The event flag (bit 0 of 0x14) becomes 1 at any clock edge where the enable is 1 and the timestamp is greater than or equal to the match value. It then stays 1 until it is cleared, even after the enable drops.
- R7: Writing 0x14 with wdata[0]=1 clears the event flag, and writing it with wdata[0]=0 has no effect. When a clear and a match fall on the same edge, the flag stays 1.
- R8: `irq` equals the event flag ANDed with the enable bit.
- R9: Writes to 0x00 and 0x04 do not alter the timestamp. Reads of any address other than 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14 return 0.
- R10: After reset the timestamp equals the CNT_INIT parameter. The match value, pending half, snapshot, enable and event flag are all 0, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timestamp advance strobe, one per microsecond |
| addr | input | ADDR_W | Byte address of the register access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (needed for the snapshot capture) |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid in the cycle of the access |
| irq | output | 1 | Match interrupt |

## Verification
A stale or missing snapshot shows up only when a carry into the upper word falls between the two count reads. The bench therefore starts the timestamp just below that carry and sweeps the gap between the two reads, so that a torn value is caught on the read pair that crosses it. A wrong compare, flag or enable register shows up at `irq` within one cycle of the edge where the match condition changes. The bench compares `irq` every cycle against an arithmetic model and checks the exact timestamp at the first interrupt for several deltas. A wrong pending half or a premature commit appears on the next read of the match registers.

// File: rtl/systmr_pkg.sv
package systmr_pkg;
    // Byte offsets of the register map
    localparam int unsigned OFS_CNT_LO = 'h00;
    localparam int unsigned OFS_CNT_HI = 'h04;
    localparam int unsigned OFS_CMP_LO = 'h08;
    localparam int unsigned OFS_CMP_HI = 'h0C;
    localparam int unsigned OFS_CTRL   = 'h10;
    localparam int unsigned OFS_STAT   = 'h14;

    // Control and status bit positions
    localparam int unsigned CTRL_EN_BIT  = 0;
    localparam int unsigned CTRL_WEN_BIT = 1;
    localparam int unsigned STAT_EVT_BIT = 0;
endpackage

// File: rtl/systmr_counter.sv
module systmr_counter #(
    parameter int unsigned CNT_W = 64,
    parameter logic [CNT_W-1:0] CNT_INIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    output logic [CNT_W-1:0] count_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= CNT_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> (count_o == $past(count_o) + 1'b1));

    // R1
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(count_o));
endmodule

// File: rtl/systmr_event.sv
module systmr_event #(
    parameter int unsigned CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             clr_i,
    output logic             evt_o,
    output logic             irq_o
);
    typedef struct packed {
        logic evt;
    } evt_state_t;

    evt_state_t st_d, st_q;
    logic       hit;

    always_comb begin
        st_d = st_q;
        hit  = en_i && (count_i >= cmp_i);
        if (clr_i) begin
            st_d.evt = 1'b0;
        end
        if (hit) begin
            st_d.evt = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.evt <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_o = st_q.evt;
    assign irq_o = st_q.evt & en_i;

    // R6
    evt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_o) |-> $past(en_i && (count_i >= cmp_i)));

    // R6
    evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o && !clr_i) |=> evt_o);

    // R7
    evt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(en_i && (count_i >= cmp_i))) |=> !evt_o);

    // R7
    evt_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && en_i && (count_i >= cmp_i)) |=> evt_o);
endmodule

// File: rtl/systmr_regs.sv
module systmr_regs
    import systmr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 5,
    localparam int unsigned CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              evt_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              en_o,
    output logic [CNT_W-1:0]  cmp_o,
    output logic              clr_o
);
    typedef struct packed {
        logic [DATA_W-1:0] shadow;
        logic [DATA_W-1:0] hold;
        logic [CNT_W-1:0]  cmp;
        logic              en;
    } reg_state_t;

    reg_state_t st_d, st_q;

    logic sel_cnt_lo, sel_cnt_hi, sel_cmp_lo, sel_cmp_hi, sel_ctrl, sel_stat;

    always_comb begin
        sel_cnt_lo = (addr_i == ADDR_W'(OFS_CNT_LO));
        sel_cnt_hi = (addr_i == ADDR_W'(OFS_CNT_HI));
        sel_cmp_lo = (addr_i == ADDR_W'(OFS_CMP_LO));
        sel_cmp_hi = (addr_i == ADDR_W'(OFS_CMP_HI));
        sel_ctrl   = (addr_i == ADDR_W'(OFS_CTRL));
        sel_stat   = (addr_i == ADDR_W'(OFS_STAT));
    end

    always_comb begin
        st_d = st_q;
        if (wr_i && sel_cmp_hi) begin
            st_d.hold = wdata_i;
        end
        if (wr_i && sel_cmp_lo) begin
            st_d.cmp = {st_q.hold, wdata_i};
        end
        if (wr_i && sel_ctrl && wdata_i[CTRL_WEN_BIT]) begin
            st_d.en = wdata_i[CTRL_EN_BIT];
        end
        if (rd_i && sel_cnt_lo) begin
            st_d.shadow = count_i[CNT_W-1:DATA_W];
        end
    end

    always_comb begin
        rdata_o = '0;
        if (sel_cnt_lo) begin
            rdata_o = count_i[DATA_W-1:0];
        end else if (sel_cnt_hi) begin
            rdata_o = st_q.shadow;
        end else if (sel_cmp_lo) begin
            rdata_o = st_q.cmp[DATA_W-1:0];
        end else if (sel_cmp_hi) begin
            rdata_o = st_q.cmp[CNT_W-1:DATA_W];
        end else if (sel_ctrl) begin
            rdata_o[CTRL_EN_BIT] = st_q.en;
        end else if (sel_stat) begin
            rdata_o[STAT_EVT_BIT] = evt_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o  = st_q.en;
    assign cmp_o = st_q.cmp;
    assign clr_o = wr_i && sel_stat && wdata_i[STAT_EVT_BIT];

    // R4
    cmp_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_cmp_lo) |=> (cmp_o == {$past(st_q.hold), $past(wdata_i)}));

    // R3
    cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && sel_cmp_lo) |=> $stable(cmp_o));

    // R5
    en_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && sel_ctrl && wdata_i[CTRL_WEN_BIT]) |=> $stable(en_o));

    // R2
    snap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && sel_cnt_lo) |=> (st_q.shadow == $past(count_i[CNT_W-1:DATA_W])));
endmodule

// File: rtl/systmr_top.sv
module systmr_top #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 5,
    parameter logic [2*DATA_W-1:0] CNT_INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    localparam int unsigned CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] cmp;
    logic             en;
    logic             evt;
    logic             clr;

    systmr_counter #(
        .CNT_W    (CNT_W),
        .CNT_INIT (CNT_INIT)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .count_o (count)
    );

    systmr_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (addr),
        .wr_i    (wr_en),
        .rd_i    (rd_en),
        .wdata_i (wdata),
        .count_i (count),
        .evt_i   (evt),
        .rdata_o (rdata),
        .en_o    (en),
        .cmp_o   (cmp),
        .clr_o   (clr)
    );

    systmr_event #(
        .CNT_W (CNT_W)
    ) u_event (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en),
        .count_i (count),
        .cmp_i   (cmp),
        .clr_i   (clr),
        .evt_o   (evt),
        .irq_o   (irq)
    );

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (en && evt));
endmodule

// File: tb/sim_systmr_top.sv
module sim_systmr_top;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 5;
    localparam logic [63:0] INIT = 64'h0000_0001_FFFF_FF80;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;
    logic [3:0] tick_pat = 4'b0000;
    int unsigned cyc = 0;

    // reference model state
    logic [63:0] cnt_m;
    logic [63:0] cmp_m;
    logic [31:0] hold_m;
    logic        en_m;
    logic        st_m;
    logic        hit_m;

    always #10 clk = ~clk;

    systmr_top #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .CNT_INIT (INIT)
    ) u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .addr  (addr),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    always @(negedge clk) begin
        cyc  <= cyc + 1;
        tick <= tick_pat[cyc % 4];
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            cnt_m  <= INIT;
            cmp_m  <= '0;
            hold_m <= '0;
            en_m   <= 1'b0;
            st_m   <= 1'b0;
        end else begin
            hit_m = en_m && (cnt_m >= cmp_m);
            if (tick) cnt_m <= cnt_m + 64'd1;
            if (hit_m) st_m <= 1'b1;
            else if (wr_en && addr == 5'h14 && wdata[0]) st_m <= 1'b0;
            if (wr_en && addr == 5'h10 && wdata[1]) en_m <= wdata[0];
            if (wr_en && addr == 5'h0C) hold_m <= wdata;
            if (wr_en && addr == 5'h08) cmp_m <= {hold_m, wdata};
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            #3;
            chk(irq === (st_m & en_m), "R8 irq vs flag&enable", {63'd0, irq}, {63'd0, st_m & en_m});
        end
    end

    task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // returns read data and the model count seen at the sample point
    task automatic bus_rd(input logic [4:0] a, output logic [31:0] d, output logic [63:0] cnt_at);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #2;
        d = rdata;
        cnt_at = cnt_m;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, lo, hi;
        logic [63:0] c, c0, tgt;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        bus_rd(5'h00, d, c); chk(d == INIT[31:0], "R10 count low after reset", d, INIT[31:0]);
        bus_rd(5'h04, d, c); chk(d == INIT[63:32], "R10 snapshot after low read", d, INIT[63:32]);
        bus_rd(5'h08, d, c); chk(d == 0, "R10 match low", d, 0);
        bus_rd(5'h0C, d, c); chk(d == 0, "R10 match high", d, 0);
        bus_rd(5'h10, d, c); chk(d == 0, "R10 control", d, 0);
        bus_rd(5'h14, d, c); chk(d == 0, "R10 status", d, 0);
        chk(irq == 1'b0, "R10 irq low", irq, 0);

        // R9 writes to count words ignored, unmapped reads zero
        bus_wr(5'h00, 32'h1234_5678);
        bus_wr(5'h04, 32'hDEAD_BEEF);
        bus_rd(5'h00, lo, c); chk(lo == INIT[31:0], "R9 count low after write", lo, INIT[31:0]);
        bus_rd(5'h04, hi, c); chk(hi == INIT[63:32], "R9 count high after write", hi, INIT[63:32]);
        for (int a = 0; a < 32; a++) begin
            if (a != 'h00 && a != 'h04 && a != 'h08 && a != 'h0C && a != 'h10 && a != 'h14) begin
                bus_rd(a[4:0], d, c);
                chk(d == 0, "R9 unmapped read", d, 0);
            end
        end

        // R1 hold while tick low
        idle(5);
        bus_rd(5'h00, d, c); chk(d == INIT[31:0], "R1 hold without tick", d, INIT[31:0]);

        // R2 coherent read pair across the carry, gap sweep
        mon_on = 1'b1;
        tick_pat = 4'b1111;
        for (int i = 0; i < 48; i++) begin
            bus_rd(5'h00, lo, c0);
            idle(i % 7);
            bus_rd(5'h04, hi, c);
            chk({hi, lo} == c0, "R2 coherent 64-bit read", {hi, lo}, c0);
        end

        // R1 increments under a sparse tick pattern
        tick_pat = 4'b0101;
        for (int i = 0; i < 12; i++) begin
            bus_rd(5'h00, d, c);
            chk(d == c[31:0], "R1 count low under sparse ticks", d, c[31:0]);
            idle(i % 3);
        end
        tick_pat = 4'b1111;

        // R5 guarded enable sweep; R6/R7 cleanup through status
        for (int s = 0; s < 2; s++) begin
            for (int w = 0; w < 4; w++) begin
                bus_wr(5'h10, 32'h2 | s);
                bus_wr(5'h10, w);
                bus_rd(5'h10, d, c);
                chk(d == ((w & 2) ? (w & 1) : s), "R5 guarded enable write", d, (w & 2) ? (w & 1) : s);
            end
        end
        bus_wr(5'h10, 32'h2);
        bus_wr(5'h14, 32'h1);
        bus_rd(5'h14, d, c); chk(d == 0, "R7 clear with enable off", d, 0);

        // R3 pending upper half, R4 commit on low write
        bus_wr(5'h0C, 32'hAAAA_5555);
        bus_rd(5'h0C, d, c); chk(d == 0, "R3 active high unchanged", d, 0);
        bus_rd(5'h08, d, c); chk(d == 0, "R3 active low unchanged", d, 0);
        bus_wr(5'h08, 32'h0000_1234);
        bus_rd(5'h0C, d, c); chk(d == 32'hAAAA_5555, "R4 committed high", d, 32'hAAAA_5555);
        bus_rd(5'h08, d, c); chk(d == 32'h0000_1234, "R4 committed low", d, 32'h1234);

        // R6 arm sequence: first interrupt at target+1 for several deltas
        for (int k = 0; k < 4; k++) begin
            int dl;
            int n;
            dl = 100 + k * 3;
            bus_wr(5'h10, 32'h2);
            bus_wr(5'h14, 32'h1);
            bus_rd(5'h00, lo, c0);
            bus_rd(5'h04, hi, c);
            tgt = {hi, lo} + 64'(dl);
            bus_wr(5'h0C, tgt[63:32]);
            bus_wr(5'h08, tgt[31:0]);
            bus_wr(5'h10, 32'h3);
            n = 0;
            @(negedge clk); #4;
            while (!irq && n < 300) begin
                chk(cnt_m <= tgt, "R6 no interrupt before match", cnt_m, tgt);
                @(negedge clk); #4;
                n++;
            end
            chk(cnt_m == tgt + 64'd1, "R6 first interrupt timestamp", cnt_m, tgt + 64'd1);
        end

        // R8 disable leaves flag set, irq low
        bus_wr(5'h10, 32'h2);
        bus_rd(5'h14, d, c); chk(d == 1, "R6 flag sticky after disable", d, 1);
        chk(irq == 1'b0, "R8 irq low with enable off", irq, 0);
        // R7 writing zero has no effect, writing one clears
        bus_wr(5'h14, 32'h0);
        bus_rd(5'h14, d, c); chk(d == 1, "R7 write zero keeps flag", d, 1);
        bus_wr(5'h14, 32'hFFFF_FFFE);
        bus_rd(5'h14, d, c); chk(d == 1, "R7 only bit0 clears", d, 1);
        bus_wr(5'h14, 32'h1);
        bus_rd(5'h14, d, c); chk(d == 0, "R7 write one clears", d, 0);
        // R7 match wins over same-cycle clear
        bus_wr(5'h10, 32'h3);
        bus_wr(5'h14, 32'h1);
        bus_rd(5'h14, d, c); chk(d == 1, "R7 match beats clear", d, 1);
        chk(irq == 1'b1, "R8 irq high", irq, 1);

        // R6 far-future match does not fire
        bus_wr(5'h10, 32'h2);
        bus_wr(5'h14, 32'h1);
        bus_wr(5'h0C, 32'hFFFF_0000);
        bus_wr(5'h08, 32'h0);
        bus_wr(5'h10, 32'h3);
        idle(20);
        bus_rd(5'h14, d, c); chk(d == 0, "R6 no match below target", d, 0);
        chk(irq == 1'b0, "R8 irq low without match", irq, 0);

        mon_on = 1'b0;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule